// File: doc/BRIEF.md
# Load-Use Interlock for an In-Order Pipeline

This block finds the one data dependency that forwarding cannot cover. A load sits in the execute stage, and the instruction right behind it in decode reads the register that the load will fill. Detection is combinational. When the condition holds, the program counter and the fetch/decode register are frozen for one clock, so fetch and decode repeat their work. At the same edge, a zero control word is written into the execute-stage control register. The instruction that enters execute is therefore a bubble. One cycle later the load has moved on, and its result can reach the waiting instruction by forwarding.

A thin wrapper is included so the stall can be observed over time. It holds a program counter that steps by 4, the decode register with its valid bit, and the execute-stage control register with the load destination field. Instruction words come from outside, addressed by the program counter. Field positions: the opcode is in bits [31:26], the first source is in [25:21], and the second source/load destination is in [20:16].

Top module: `load_use_interlock`

## Requirements
- R1: `bubble_sel` is 1 in any cycle where the execute-stage control word has its memory-read bit set and that stage's destination field (bits [20:16] of the load) equals bit field [25:21] or bit field [20:16] of the word in decode.
- R2: An instruction in execute whose memory-read bit is clear never causes a stall, even when its [20:16] field matches a decode source.
- R3: While `bubble_sel` is 1, `pc_we` and `dec_we` are 0, and at the next edge `pc` and `dec_instr` keep their values. Otherwise `pc` advances by 4 and `dec_instr` loads `fetch_instr`.
- R4: At the edge that ends a stall cycle, `ex_ctrl` becomes all zero.
- R5: When decode holds no valid instruction (its `fetch_valid` was 0), the control word passed to execute is all zero.
- R6: The control word is 6 bits {reg_write, mem_read, mem_write, mem_to_reg, alu_imm, dst_from_rd} (bit 5 down to bit 0). Opcode 6'h23 (load) gives 6'h36, opcode 6'h2B (store) gives 6'h0A, opcode 6'h00 (register operation) gives 6'h21, and any other opcode gives 6'h00.
- R7: A load followed by an instruction that does not read its destination causes no stall. This includes a second, independent load.
- R8: A dependent use adds exactly one cycle: a stall cycle is never followed by another stall cycle.
- R9: Reset (asynchronous, active low) sets `pc` to 0, clears `dec_instr` and its valid bit, and sets `ex_ctrl` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_instr | input | 32 | Instruction word at address `pc` |
| fetch_valid | input | 1 | `fetch_instr` is a real instruction |
| pc | output | 32 | Program counter |
| dec_instr | output | 32 | Word held in the fetch/decode register |
| pc_we | output | 1 | Program counter update enable |
| dec_we | output | 1 | Fetch/decode register update enable |
| bubble_sel | output | 1 | Hazard seen; zero control goes to execute |
| ex_ctrl | output | 6 | Execute-stage control word |

## Verification
`bubble_sel`, `pc_we` and `dec_we` are combinational. They are due in the same cycle that the load sits in execute and its consumer sits in decode. The frozen `pc`/`dec_instr` and the zeroed `ex_ctrl` are due one rising edge later. The bench samples every output on the falling edge that follows each rising edge. Its table records which entries cost a stall cycle, and from that it counts how many edges separate each instruction's arrival in decode. A word's control code is expected in `ex_ctrl` on the edge after that word leaves decode.

// File: rtl/lui_pkg.sv
package lui_pkg;
  localparam int OPC_W  = 6;
  localparam int CTRL_W = 6;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
  localparam logic [OPC_W-1:0] OPC_REGOP = 6'h00;

  typedef struct packed {
    logic reg_write;
    logic mem_read;
    logic mem_write;
    logic mem_to_reg;
    logic alu_imm;
    logic dst_from_rd;
  } ctrl_t;

  // Control word for one opcode; an empty stage yields all zero.
  function automatic ctrl_t decode_ctrl(input logic [OPC_W-1:0] opc, input logic valid);
    ctrl_t c;
    c = '0;
    if (valid) begin
      case (opc)
        OPC_LOAD:  begin c.reg_write = 1'b1; c.mem_read = 1'b1; c.mem_to_reg = 1'b1; c.alu_imm = 1'b1; end
        OPC_STORE: begin c.mem_write = 1'b1; c.alu_imm = 1'b1; end
        OPC_REGOP: begin c.reg_write = 1'b1; c.dst_from_rd = 1'b1; end
        default:   c = '0;
      endcase
    end
    return c;
  endfunction

  // Load-use condition on register numbers.
  function automatic logic load_use(input logic ex_rd_mem, input logic [4:0] ex_dst,
                                    input logic [4:0] src_a, input logic [4:0] src_b);
    return ex_rd_mem && ((ex_dst == src_a) || (ex_dst == src_b));
  endfunction
endpackage

// File: rtl/lui_detect.sv
module lui_detect (
  input  logic       ex_mem_read,
  input  logic [4:0] ex_dst,
  input  logic [4:0] dec_src_a,
  input  logic [4:0] dec_src_b,
  output logic       hazard
);
  always_comb hazard = lui_pkg::load_use(ex_mem_read, ex_dst, dec_src_a, dec_src_b);
endmodule

// File: rtl/lui_front.sv
module lui_front #(
  parameter int PC_W    = 32,
  parameter int INSTR_W = 32,
  parameter int PC_STEP = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold,
  input  logic [INSTR_W-1:0] fetch_instr,
  input  logic               fetch_valid,
  output logic [PC_W-1:0]    pc,
  output logic [INSTR_W-1:0] dec_instr,
  output logic               dec_valid
);
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc        <= '0;
      dec_instr <= '0;
      dec_valid <= 1'b0;
    end else if (!hold) begin
      pc        <= pc + STEP;
      dec_instr <= fetch_instr;
      dec_valid <= fetch_valid;
    end
  end

  assert_front_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (pc == $past(pc)) && (dec_instr == $past(dec_instr)));
  assert_front_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> (pc == $past(pc) + STEP) && (dec_instr == $past(fetch_instr)));
endmodule

// File: rtl/lui_ex_ctrl.sv
module lui_ex_ctrl (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bubble,
  input  lui_pkg::ctrl_t dec_ctrl,
  input  logic [4:0]    dec_dst,
  output lui_pkg::ctrl_t ex_ctrl,
  output logic [4:0]    ex_dst
);
  lui_pkg::ctrl_t ctrl_in;
  always_comb ctrl_in = bubble ? lui_pkg::ctrl_t'('0) : dec_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_ctrl <= '0;
      ex_dst  <= '0;
    end else begin
      ex_ctrl <= ctrl_in;
      ex_dst  <= dec_dst;
    end
  end

  assert_bubble_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> (ex_ctrl == lui_pkg::ctrl_t'('0)));
endmodule

// File: rtl/load_use_interlock.sv
module load_use_interlock #(
  parameter int PC_W    = 32,
  parameter int INSTR_W = 32,
  parameter int REG_AW  = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [INSTR_W-1:0]          fetch_instr,
  input  logic                        fetch_valid,
  output logic [PC_W-1:0]             pc,
  output logic [INSTR_W-1:0]          dec_instr,
  output logic                        pc_we,
  output logic                        dec_we,
  output logic                        bubble_sel,
  output logic [lui_pkg::CTRL_W-1:0]  ex_ctrl
);
  import lui_pkg::*;
  localparam int OPC_LSB = INSTR_W - OPC_W;
  localparam int SA_LSB  = OPC_LSB - REG_AW;
  localparam int SB_LSB  = SA_LSB - REG_AW;

  logic              dec_valid;
  logic [OPC_W-1:0]  dec_opc;
  logic [REG_AW-1:0] dec_src_a, dec_src_b, ex_dst;
  ctrl_t             dec_ctrl, ex_ctrl_q;
  logic              hazard;

  always_comb begin
    dec_opc   = dec_instr[OPC_LSB +: OPC_W];
    dec_src_a = dec_instr[SA_LSB +: REG_AW];
    dec_src_b = dec_instr[SB_LSB +: REG_AW];
    dec_ctrl  = decode_ctrl(dec_opc, dec_valid);
  end

  lui_detect u_detect (
    .ex_mem_read (ex_ctrl_q.mem_read),
    .ex_dst      (ex_dst),
    .dec_src_a   (dec_src_a),
    .dec_src_b   (dec_src_b),
    .hazard      (hazard)
  );

  lui_front #(.PC_W(PC_W), .INSTR_W(INSTR_W), .PC_STEP(4)) u_front (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold        (hazard),
    .fetch_instr (fetch_instr),
    .fetch_valid (fetch_valid),
    .pc          (pc),
    .dec_instr   (dec_instr),
    .dec_valid   (dec_valid)
  );

  lui_ex_ctrl u_exc (
    .clk      (clk),
    .rst_n    (rst_n),
    .bubble   (hazard),
    .dec_ctrl (dec_ctrl),
    .dec_dst  (dec_src_b),
    .ex_ctrl  (ex_ctrl_q),
    .ex_dst   (ex_dst)
  );

  always_comb begin
    pc_we      = !hazard;
    dec_we     = !hazard;
    bubble_sel = hazard;
    ex_ctrl    = ex_ctrl_q;
  end

  localparam ctrl_t LOAD_CTRL = decode_ctrl(OPC_LOAD, 1'b1);

  assert_only_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hazard |-> (ex_ctrl_q == LOAD_CTRL));
  assert_single_bubble_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hazard |=> !hazard);
  assert_empty_stage_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |=> (ex_ctrl_q == ctrl_t'('0)));
endmodule

// File: tb/load_use_interlock_tb.sv
`timescale 1ns/1ps
module load_use_interlock_tb;
  localparam int N = 14;
  // {stall, ctrl[5:0], opcode, src_a, src_b/dst, rd, pad}
  localparam logic [38:0] PROG [N] = '{
    {1'b0, 6'h36, 6'h23, 5'd1,  5'd2,  5'd0,  11'd0},  // load r2
    {1'b1, 6'h21, 6'h00, 5'd2,  5'd5,  5'd4,  11'd0},  // uses r2 in src_a: stall
    {1'b0, 6'h21, 6'h00, 5'd6,  5'd2,  5'd8,  11'd0},
    {1'b0, 6'h36, 6'h23, 5'd1,  5'd3,  5'd0,  11'd0},  // load r3
    {1'b0, 6'h36, 6'h23, 5'd7,  5'd6,  5'd0,  11'd0},  // independent load
    {1'b1, 6'h21, 6'h00, 5'd1,  5'd6,  5'd9,  11'd0},  // uses r6 in src_b: stall
    {1'b0, 6'h0A, 6'h2B, 5'd2,  5'd6,  5'd0,  11'd0},  // store
    {1'b0, 6'h36, 6'h23, 5'd0,  5'd10, 5'd0,  11'd0},  // load r10
    {1'b0, 6'h21, 6'h00, 5'd12, 5'd13, 5'd11, 11'd0},  // unrelated
    {1'b0, 6'h36, 6'h23, 5'd1,  5'd5,  5'd0,  11'd0},  // load r5
    {1'b1, 6'h0A, 6'h2B, 5'd3,  5'd5,  5'd0,  11'd0},  // store of r5: stall
    {1'b0, 6'h36, 6'h23, 5'd1,  5'd9,  5'd0,  11'd0},  // load r9
    {1'b1, 6'h00, 6'h3F, 5'd9,  5'd0,  5'd0,  11'd0},  // unknown opcode reading r9: stall
    {1'b0, 6'h21, 6'h00, 5'd0,  5'd9,  5'd1,  11'd0}   // src_a r0 matches non-load dst
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] fetch_instr, pc, dec_instr;
  logic fetch_valid, pc_we, dec_we, bubble_sel;
  logic [5:0] ex_ctrl;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  always_comb begin
    if ((pc >> 2) < N) begin
      fetch_instr = PROG[pc >> 2][31:0];
      fetch_valid = 1'b1;
    end else begin
      fetch_instr = '0;
      fetch_valid = 1'b0;
    end
  end

  load_use_interlock u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_instr(fetch_instr), .fetch_valid(fetch_valid),
    .pc(pc), .dec_instr(dec_instr), .pc_we(pc_we), .dec_we(dec_we),
    .bubble_sel(bubble_sel), .ex_ctrl(ex_ctrl)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 pc after reset", pc, 32'd0);
    chk("R9 ex_ctrl after reset", {26'd0, ex_ctrl}, 32'd0);
    chk("R9 dec_instr after reset", dec_instr, 32'd0);
    rst_n = 1'b1;
    chk("R9 no stall out of reset", {31'd0, bubble_sel}, 32'd0);

    for (int i = 0; i < N; i++) begin
      logic st;
      st = PROG[i][38];
      @(negedge clk);
      chk($sformatf("R3 pc entry %0d", i), pc, 32'(4 * (i + 1)));
      chk($sformatf("R3 dec_instr entry %0d", i), dec_instr, PROG[i][31:0]);
      chk($sformatf("%s bubble_sel entry %0d", st ? "R1" : "R7", i), {31'd0, bubble_sel}, {31'd0, st});
      chk($sformatf("R3 pc_we/dec_we entry %0d", i), {30'd0, pc_we, dec_we}, {30'd0, !st, !st});
      if (i == 0) chk("R5 empty decode gave zero control", {26'd0, ex_ctrl}, 32'd0);
      else chk($sformatf("R6 ex_ctrl of entry %0d", i - 1), {26'd0, ex_ctrl}, {26'd0, PROG[i-1][37:32]});
      if (i == 13) chk("R2 non-load dst match no stall", {31'd0, bubble_sel}, 32'd0);
      if (st) begin
        @(negedge clk);
        chk($sformatf("R4 bubble in ex after entry %0d", i), {26'd0, ex_ctrl}, 32'd0);
        chk($sformatf("R3 pc held entry %0d", i), pc, 32'(4 * (i + 1)));
        chk($sformatf("R3 dec_instr held entry %0d", i), dec_instr, PROG[i][31:0]);
        chk($sformatf("R8 single stall entry %0d", i), {31'd0, bubble_sel}, 32'd0);
      end
    end
    @(negedge clk);
    chk("R6 ex_ctrl of last entry", {26'd0, ex_ctrl}, {26'd0, PROG[N-1][37:32]});
    @(negedge clk);
    chk("R5 invalid decode gives zero control", {26'd0, ex_ctrl}, 32'd0);

    // Reset in the middle of a stall.
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 stall on re-run", {31'd0, bubble_sel}, 32'd1);
    rst_n = 1'b0;
    #1;
    chk("R9 async reset pc", pc, 32'd0);
    chk("R9 async reset ex_ctrl", {26'd0, ex_ctrl}, 32'd0);
    chk("R9 async reset dec_instr", dec_instr, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 restart pc", pc, 32'd4);
    chk("R9 restart ex_ctrl zero", {26'd0, ex_ctrl}, 32'd0);

    done = 1;
    summary();
    $finish;
  end
endmodule